// File: doc/BRIEF.md
# Indexed Packet Memory Data Port

This block gives a host access to a 16 KB packet memory through two locations: an index register and a 16-bit data port. The host first writes an index value with the data-select input low. Data-port reads and writes that follow act on whatever index is currently latched. Two byte pointers address the memory. The write pointer covers the transmit region, bytes 0 to 3071. The read pointer covers the receive region, bytes 3072 to 16383.

Data accesses move 16 bits. The low byte sits at the even byte address, so the data word maps directly onto one memory word. Some index codes move the pointer by two bytes after the access, and others only peek. When a pointer reaches the end of its region it either wraps or holds, depending on an auto-wrap control bit. A read aimed at an empty receive ring returns zero. The ring is empty when the read pointer equals the receive write pointer, which the receive engine supplies.

The memory itself sits outside the block, behind a word-addressed synchronous port with a read latency of one cycle. A control FSM sequences each read through three states:
- **IDLE** accepts a request and goes to **FETCH** (IDLE→FETCH).
- **FETCH** captures the memory word and goes to **REPLY** (FETCH→REPLY).
- **REPLY** presents the result for one cycle and returns to **IDLE** (REPLY→IDLE).
- A soft reset sends any state back to **IDLE**.

Writes complete inside **IDLE**.

Top module: `pktport_dataport`

## Requirements
- R1: A write with `bus_sel_data`=0 stores `bus_wdata[7:0]` as the index. Every data-port access (`bus_sel_data`=1) decodes the most recently stored index.
- R2: At index 0xF8, a data write stores `bus_wdata` at word `wr_ptr[13:1]` (low byte at the even address) and then adds 2 to the write pointer. Index 0xF6 performs the same store and leaves the pointer unchanged.
- R3: At index 0xF2, a data read returns the word at `rd_ptr[13:1]` and adds 2 to the read pointer. Index 0xF0 returns the same word and leaves the pointer unchanged. Every data read raises `bus_rvalid` for exactly one cycle, two cycles after the request cycle, and `bus_rdata` is 0 whenever `bus_rvalid` is low.
- R4: With auto-wrap set (bit 7 of the value written at index 0xFF), the write pointer steps from 3070 to 0 and the read pointer steps from 16382 to 3072.
- R5: With auto-wrap clear, a pointer advances only if the new value is below its region end (3072 for write, 16384 for read). Otherwise it holds its value.
- R6: A write at 0xFF that changes auto-wrap from 0 to 1 sets the read pointer high byte to 0x0C and keeps its low byte. A write that leaves the bit at 1 does not touch the pointer. A read at 0xFF returns auto-wrap in bit 7.
- R7: When `rd_ptr` equals `rx_wptr`, a read at 0xF0 or 0xF2 returns 0, issues no memory read, and leaves the read pointer unchanged.
- R8: The read pointer bytes are accessed at 0xF4 (low) and 0xF5 (high). The write pointer bytes are accessed at 0xFA (low) and 0xFB (high). Each is readable and writable through `bus_wdata[7:0]`. Reads at any other index return 0, and writes there change nothing.
- R9: `soft_rst` sets the write pointer to 0, the read pointer to 3072 and auto-wrap to 0, and it aborts a read in flight so that no `bus_rvalid` appears. It overrides a bus access in the same cycle, which then writes no memory.
- R10: After `rst_n` is released, the write pointer is 0, the read pointer is 3072, the index is 0, auto-wrap is 0, and `bus_rvalid` and `mem_we` are low.
- R11: Bus requests that arrive while a read is in flight (FSM not in IDLE) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset of pointers and control |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_sel_data | input | 1 | 0 selects the index register, 1 selects the data port |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | One-cycle read response strobe |
| rx_wptr | input | 16 | Receive write pointer (byte address) |
| mem_addr | output | 13 | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write word |
| mem_re | output | 1 | Memory read enable |
| mem_rdata | input | 16 | Memory read word, one cycle after mem_re |

## Verification
Two functions can collide in one cycle: a soft reset and a pointer-advancing access. The bench provokes this in two ways. It asserts `soft_rst` in the same cycle as a data write at 0xF8, and it asserts `soft_rst` during the FETCH cycle of a read. The cycle-level reference model expects no memory write and no response in these cases, with both pointers back at their reset values. A second overlap is the auto-wrap enable write, which both sets the control bit and overwrites the read pointer high byte. It is judged by reading back both pointer bytes afterwards.

// File: rtl/pktport_pkg.sv
package pktport_pkg;

    localparam int PTR_W = 16;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_FETCH = 2'd1,
        PS_REPLY = 2'd2
    } pp_state_e;

    // index codes decoded by the data port
    localparam logic [7:0] IX_RD_PEEK = 8'hF0;
    localparam logic [7:0] IX_RD_STEP = 8'hF2;
    localparam logic [7:0] IX_RP_LO   = 8'hF4;
    localparam logic [7:0] IX_RP_HI   = 8'hF5;
    localparam logic [7:0] IX_WR_PEEK = 8'hF6;
    localparam logic [7:0] IX_WR_STEP = 8'hF8;
    localparam logic [7:0] IX_WP_LO   = 8'hFA;
    localparam logic [7:0] IX_WP_HI   = 8'hFB;
    localparam logic [7:0] IX_CTRL    = 8'hFF;

    localparam int WRAP_BIT = 7;

endpackage

// File: rtl/pktport_ptr.sv
module pktport_ptr
    import pktport_pkg::*;
#(
    parameter int REG_LO  = 0,
    parameter int REG_END = 3072,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic [7:0]       ld_byte,
    input  logic             step,
    input  logic             wrap_en,
    input  logic             force_hi,
    input  logic [7:0]       force_byte,
    output logic [PTR_W-1:0] ptr
);

    localparam logic [PTR_W:0]   END_V  = REG_END[PTR_W:0];
    localparam logic [PTR_W:0]   SPAN_V = END_V - REG_LO[PTR_W:0];
    localparam logic [PTR_W-1:0] LO_V   = REG_LO[PTR_W-1:0];
    localparam logic [PTR_W-1:0] RST_V  = RST_VAL[PTR_W-1:0];

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W:0]   sum;
    logic [PTR_W-1:0] nxt;

    always_comb begin
        sum = {1'b0, ptr_q} + {{(PTR_W-1){1'b0}}, 2'd2};
        if (wrap_en) begin
            if (sum >= END_V) nxt = PTR_W'(sum - SPAN_V);
            else              nxt = sum[PTR_W-1:0];
        end else begin
            if (sum < END_V) nxt = sum[PTR_W-1:0];
            else             nxt = ptr_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ptr_q <= RST_V;
        else if (soft_rst)  ptr_q <= RST_V;
        else if (force_hi)  ptr_q[PTR_W-1:8] <= force_byte;
        else if (ld_lo)     ptr_q[7:0] <= ld_byte;
        else if (ld_hi)     ptr_q[PTR_W-1:8] <= ld_byte;
        else if (step)      ptr_q <= nxt;
    end

    assign ptr = ptr_q;

    // R9
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ptr == RST_V));

    // R5
    clip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wrap_en && !soft_rst && !force_hi && !ld_lo && !ld_hi &&
         ({1'b0, ptr} + 17'd2 >= END_V)) |=> $stable(ptr));

    // R4
    wrap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && wrap_en && !soft_rst && !force_hi && !ld_lo && !ld_hi &&
         ptr >= LO_V && {1'b0, ptr} < END_V) |=> (ptr >= LO_V && {1'b0, ptr} < END_V));

    // R6
    force_keep_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_hi && !soft_rst) |=> (ptr[7:0] == $past(ptr[7:0])));

endmodule

// File: rtl/pktport_fsm.sv
module pktport_fsm
    import pktport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic rd_go,
    output logic idle,
    output logic fetch,
    output logic reply
);

    pp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (soft_rst) begin
            state_d = PS_IDLE;
        end else begin
            unique case (state_q)
                PS_IDLE:  if (rd_go) state_d = PS_FETCH;
                PS_FETCH: state_d = PS_REPLY;
                PS_REPLY: state_d = PS_IDLE;
                default:  state_d = PS_IDLE;
            endcase
        end
    end

    always_comb begin
        idle  = (state_q == PS_IDLE);
        fetch = (state_q == PS_FETCH);
        reply = (state_q == PS_REPLY);
    end

    // R3
    fetch_to_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && !soft_rst) |=> reply);

    // R3
    reply_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reply |=> !reply);

endmodule

// File: rtl/pktport_dataport.sv
module pktport_dataport
    import pktport_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int TX_BYTES  = 3072,
    parameter int MEM_BYTES = 16384
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_sel_data,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [15:0]       rx_wptr,
    output logic [ADDR_W-2:0] mem_addr,
    output logic              mem_we,
    output logic [15:0]       mem_wdata,
    output logic              mem_re,
    input  logic [15:0]       mem_rdata
);

    localparam int RX_BASE = TX_BYTES;

    logic [7:0]       idx_q;
    logic             wrap_q;
    logic [15:0]      rd_data_q;
    logic             use_mem_q;
    logic             idle, fetch, reply;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    logic go_wr, go_rd, data_wr, idx_wr;
    logic ring_empty, is_rd_mem, rd_step, wr_step;
    logic wrap_rise;
    logic [15:0] reg_val;

    // acceptance only in IDLE; soft reset overrides
    always_comb begin
        go_wr      = idle && bus_wr && !soft_rst;
        go_rd      = idle && bus_rd && !bus_wr && bus_sel_data && !soft_rst;
        data_wr    = go_wr && bus_sel_data;
        idx_wr     = go_wr && !bus_sel_data;
        ring_empty = (rd_ptr == rx_wptr);
        is_rd_mem  = (idx_q == IX_RD_PEEK) || (idx_q == IX_RD_STEP);
        mem_re     = go_rd && is_rd_mem && !ring_empty;
        rd_step    = mem_re && (idx_q == IX_RD_STEP);
        mem_we     = data_wr && ((idx_q == IX_WR_PEEK) || (idx_q == IX_WR_STEP));
        wr_step    = data_wr && (idx_q == IX_WR_STEP);
        wrap_rise  = data_wr && (idx_q == IX_CTRL) && bus_wdata[WRAP_BIT] && !wrap_q;
        mem_addr   = mem_we ? wr_ptr[ADDR_W-1:1] : rd_ptr[ADDR_W-1:1];
        mem_wdata  = bus_wdata;
    end

    always_comb begin
        unique case (idx_q)
            IX_RP_LO: reg_val = {8'h00, rd_ptr[7:0]};
            IX_RP_HI: reg_val = {8'h00, rd_ptr[PTR_W-1:8]};
            IX_WP_LO: reg_val = {8'h00, wr_ptr[7:0]};
            IX_WP_HI: reg_val = {8'h00, wr_ptr[PTR_W-1:8]};
            IX_CTRL:  reg_val = {8'h00, wrap_q, 7'b0};
            default:  reg_val = 16'h0000;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= 8'h00;
        end else if (idx_wr) begin
            idx_q <= bus_wdata[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             wrap_q <= 1'b0;
        else if (soft_rst)                      wrap_q <= 1'b0;
        else if (data_wr && idx_q == IX_CTRL)   wrap_q <= bus_wdata[WRAP_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q <= 16'h0000;
            use_mem_q <= 1'b0;
        end else if (go_rd) begin
            rd_data_q <= is_rd_mem ? 16'h0000 : reg_val;
            use_mem_q <= mem_re;
        end else if (fetch && use_mem_q) begin
            rd_data_q <= mem_rdata;
        end
    end

    always_comb begin
        bus_rvalid = reply;
        bus_rdata  = reply ? rd_data_q : 16'h0000;
    end

    pktport_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .rd_go    (go_rd),
        .idle     (idle),
        .fetch    (fetch),
        .reply    (reply)
    );

    pktport_ptr #(
        .REG_LO  (0),
        .REG_END (TX_BYTES),
        .RST_VAL (0)
    ) u_wr_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .ld_lo      (data_wr && idx_q == IX_WP_LO),
        .ld_hi      (data_wr && idx_q == IX_WP_HI),
        .ld_byte    (bus_wdata[7:0]),
        .step       (wr_step),
        .wrap_en    (wrap_q),
        .force_hi   (1'b0),
        .force_byte (8'h00),
        .ptr        (wr_ptr)
    );

    pktport_ptr #(
        .REG_LO  (RX_BASE),
        .REG_END (MEM_BYTES),
        .RST_VAL (RX_BASE)
    ) u_rd_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .ld_lo      (data_wr && idx_q == IX_RP_LO),
        .ld_hi      (data_wr && idx_q == IX_RP_HI),
        .ld_byte    (bus_wdata[7:0]),
        .step       (rd_step),
        .wrap_en    (wrap_q),
        .force_hi   (wrap_rise),
        .force_byte (RX_BASE[15:8]),
        .ptr        (rd_ptr)
    );

    // R7
    empty_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel_data && ring_empty) |-> !mem_re);

    // R7
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (go_rd && is_rd_mem && ring_empty) |=> ##1 (bus_rvalid && bus_rdata == 16'h0000));

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> (!mem_we && !mem_re));

    // R3
    rvalid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        mem_re |=> ##1 bus_rvalid);

    // R9
    srst_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> !mem_we);

endmodule

// File: tb/pktport_dataport_tb.sv
module pktport_dataport_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_sel_data = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        bus_rvalid;
    logic [15:0] rx_wptr = 16'hFFFF;
    logic [12:0] mem_addr;
    logic        mem_we, mem_re;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 16'h0;

    always #10 clk = ~clk;

    pktport_dataport u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel_data(bus_sel_data),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .rx_wptr(rx_wptr), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    // memory stub
    logic [15:0] stub_mem [int];
    always @(posedge clk) begin
        if (mem_we) stub_mem[int'(mem_addr)] = mem_wdata;
        if (mem_re) mem_rdata <= stub_mem.exists(int'(mem_addr)) ? stub_mem[int'(mem_addr)] : 16'h0;
    end

    int checks = 0;
    int fails = 0;
    string phase = "R10";

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    // behavioural reference model
    logic [15:0] ref_mem [int];
    int m_wp = 0, m_rp = 3072, m_wrap = 0, m_idx = 0, m_st = 0, m_pend = 0;
    logic [15:0] last_rd;
    int rv_seen = 0;

    function automatic int ref_read(input int a);
        return ref_mem.exists(a) ? int'(ref_mem[a]) : 0;
    endfunction

    function automatic int adv_w(input int p, input int wr);
        int n = p + 2;
        if (wr != 0) return (n >= 3072) ? n - 3072 : n;
        return (n < 3072) ? n : p;
    endfunction

    function automatic int adv_r(input int p, input int wr);
        int n = p + 2;
        if (wr != 0) return (n >= 16384) ? n - 13312 : n;
        return (n < 16384) ? n : p;
    endfunction

    task automatic tick(input logic w, input logic r, input logic s,
                        input logic [15:0] d, input logic sr);
        int exp_we, exp_re, exp_rv;
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_sel_data = s; bus_wdata = d; soft_rst = sr;
        #2;
        exp_rv = (m_st == 2) ? 1 : 0;
        exp_we = (m_st == 0 && !sr && w && s && (m_idx == 'hF6 || m_idx == 'hF8)) ? 1 : 0;
        exp_re = (m_st == 0 && !sr && !w && r && s && (m_idx == 'hF0 || m_idx == 'hF2)
                  && m_rp != int'(rx_wptr)) ? 1 : 0;
        check(phase, "rvalid", int'(bus_rvalid), exp_rv);
        check(phase, "rdata", int'(bus_rdata), exp_rv != 0 ? m_pend : 0);
        check(phase, "mem_we", int'(mem_we), exp_we);
        check(phase, "mem_re", int'(mem_re), exp_re);
        if (exp_we != 0) begin
            check(phase, "wr addr", int'(mem_addr), (m_wp >> 1) & 'h1FFF);
            check(phase, "wr data", int'(mem_wdata), int'(d));
        end
        if (exp_re != 0) check(phase, "rd addr", int'(mem_addr), (m_rp >> 1) & 'h1FFF);
        if (bus_rvalid) begin last_rd = bus_rdata; rv_seen++; end
        // model update for the coming edge
        if (sr) begin
            m_wp = 0; m_rp = 3072; m_wrap = 0; m_st = 0;
        end else if (m_st == 2) m_st = 0;
        else if (m_st == 1) m_st = 2;
        else if (w) begin
            if (!s) m_idx = int'(d[7:0]);
            else case (m_idx)
                'hF8: begin ref_mem[(m_wp >> 1) & 'h1FFF] = d; m_wp = adv_w(m_wp, m_wrap); end
                'hF6: ref_mem[(m_wp >> 1) & 'h1FFF] = d;
                'hF4: m_rp = (m_rp & 'hFF00) | int'(d[7:0]);
                'hF5: m_rp = (m_rp & 'hFF) | (int'(d[7:0]) << 8);
                'hFA: m_wp = (m_wp & 'hFF00) | int'(d[7:0]);
                'hFB: m_wp = (m_wp & 'hFF) | (int'(d[7:0]) << 8);
                'hFF: begin
                    if (m_wrap == 0 && d[7]) m_rp = (m_rp & 'hFF) | 'h0C00;
                    m_wrap = d[7] ? 1 : 0;
                end
                default: ;
            endcase
        end else if (r && s) begin
            m_st = 1;
            case (m_idx)
                'hF0, 'hF2: begin
                    if (m_rp == int'(rx_wptr)) m_pend = 0;
                    else begin
                        m_pend = ref_read((m_rp >> 1) & 'h1FFF);
                        if (m_idx == 'hF2) m_rp = adv_r(m_rp, m_wrap);
                    end
                end
                'hF4: m_pend = m_rp & 'hFF;
                'hF5: m_pend = (m_rp >> 8) & 'hFF;
                'hFA: m_pend = m_wp & 'hFF;
                'hFB: m_pend = (m_wp >> 8) & 'hFF;
                'hFF: m_pend = m_wrap << 7;
                default: m_pend = 0;
            endcase
        end
    endtask

    task automatic set_idx(input logic [7:0] v);
        tick(1'b1, 1'b0, 1'b0, {8'h00, v}, 1'b0);
    endtask

    task automatic wr_data(input logic [15:0] v);
        tick(1'b1, 1'b0, 1'b1, v, 1'b0);
    endtask

    task automatic rd_data();
        last_rd = 16'hDEAD;
        tick(1'b0, 1'b1, 1'b1, 16'h0, 1'b0);
        tick(1'b0, 1'b0, 1'b0, 16'h0, 1'b0);
        tick(1'b0, 1'b0, 1'b0, 16'h0, 1'b0);
    endtask

    task automatic expect_at(input string tag, input logic [7:0] ix, input int exp);
        set_idx(ix);
        rd_data();
        check(tag, $sformatf("read idx %0h", ix), int'(last_rd), exp);
    endtask

    task automatic set_wp(input int v);
        set_idx(8'hFA); wr_data(16'(v & 'hFF));
        set_idx(8'hFB); wr_data(16'((v >> 8) & 'hFF));
    endtask

    task automatic set_rp(input int v);
        set_idx(8'hF4); wr_data(16'(v & 'hFF));
        set_idx(8'hF5); wr_data(16'((v >> 8) & 'hFF));
    endtask

    bit done = 0;
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs quiet in reset
        check("R10", "rvalid in reset", int'(bus_rvalid), 0);
        check("R10", "mem_we in reset", int'(mem_we), 0);
        @(negedge clk);
        rst_n = 1'b1;

        phase = "R10";
        expect_at("R10", 8'hFA, 'h00);
        expect_at("R10", 8'hFB, 'h00);
        expect_at("R10", 8'hF4, 'h00);
        expect_at("R10", 8'hF5, 'h0C);
        expect_at("R10", 8'hFF, 'h00);

        phase = "R2";
        set_idx(8'hF8);
        wr_data(16'h1234);
        wr_data(16'hABCD);
        expect_at("R2", 8'hFA, 'h04);
        set_rp(0);
        phase = "R3";
        set_idx(8'hF0);
        rd_data(); check("R3", "peek", int'(last_rd), 'h1234);
        rd_data(); check("R3", "peek again", int'(last_rd), 'h1234);
        expect_at("R3", 8'hF4, 'h00);
        set_idx(8'hF2);
        rd_data(); check("R3", "step 1", int'(last_rd), 'h1234);
        rd_data(); check("R3", "step 2", int'(last_rd), 'hABCD);
        expect_at("R3", 8'hF4, 'h04);
        phase = "R2";
        set_idx(8'hF6);
        wr_data(16'h5555);
        expect_at("R2", 8'hFA, 'h04);
        set_rp(4);
        expect_at("R2", 8'hF0, 'h5555);

        phase = "R1";
        expect_at("R1", 8'hFA, 'h04);
        expect_at("R1", 8'hFB, 'h00);

        phase = "R5";
        set_wp(3068);
        set_idx(8'hF8);
        wr_data(16'h1111);
        wr_data(16'h2222);
        expect_at("R5", 8'hFA, 'hFE);
        expect_at("R5", 8'hFB, 'h0B);
        set_rp(16380);
        set_idx(8'hF2);
        rd_data();
        rd_data();
        expect_at("R5", 8'hF4, 'hFE);
        expect_at("R5", 8'hF5, 'h3F);

        phase = "R6";
        set_rp('h0034);
        set_idx(8'hFF);
        wr_data(16'h0080);
        expect_at("R6", 8'hF5, 'h0C);
        expect_at("R6", 8'hF4, 'h34);
        expect_at("R6", 8'hFF, 'h80);
        set_rp('h0010);
        set_idx(8'hFF);
        wr_data(16'h0080);
        expect_at("R6", 8'hF5, 'h00);
        expect_at("R6", 8'hF4, 'h10);

        phase = "R4";
        set_wp(3070);
        set_idx(8'hF8);
        wr_data(16'h3333);
        expect_at("R4", 8'hFA, 'h00);
        expect_at("R4", 8'hFB, 'h00);
        set_idx(8'hF8);
        wr_data(16'h4444);
        expect_at("R4", 8'hFA, 'h02);
        set_rp(16382);
        set_idx(8'hF2);
        rd_data();
        expect_at("R4", 8'hF4, 'h00);
        expect_at("R4", 8'hF5, 'h0C);

        phase = "R7";
        set_rp(4);
        rx_wptr = 16'd4;
        expect_at("R7", 8'hF2, 'h0000);
        expect_at("R7", 8'hF4, 'h04);
        rx_wptr = 16'hFFFF;
        expect_at("R7", 8'hF0, 'h5555);

        phase = "R8";
        set_idx(8'h10);
        wr_data(16'h00AB);
        expect_at("R8", 8'h10, 'h00);
        expect_at("R8", 8'hFA, 'h02);
        expect_at("R8", 8'hF4, 'h04);

        phase = "R11";
        set_idx(8'hF8);
        tick(1'b0, 1'b1, 1'b1, 16'h0, 1'b0);
        tick(1'b1, 1'b0, 1'b1, 16'h7777, 1'b0);
        tick(1'b1, 1'b0, 1'b0, 16'h00F4, 1'b0);
        tick(1'b0, 1'b0, 1'b0, 16'h0, 1'b0);
        expect_at("R11", 8'hFA, 'h02);

        phase = "R9";
        set_idx(8'hF8);
        tick(1'b1, 1'b0, 1'b1, 16'h9999, 1'b1);
        expect_at("R9", 8'hFA, 'h00);
        expect_at("R9", 8'hF5, 'h0C);
        expect_at("R9", 8'hF4, 'h00);
        expect_at("R9", 8'hFF, 'h00);
        set_rp(4);
        set_idx(8'hF0);
        rv_seen = 0;
        tick(1'b0, 1'b1, 1'b1, 16'h0, 1'b0);
        tick(1'b0, 1'b0, 1'b0, 16'h0, 1'b1);
        tick(1'b0, 1'b0, 1'b0, 16'h0, 1'b0);
        tick(1'b0, 1'b0, 1'b0, 16'h0, 1'b0);
        check("R9", "aborted read response count", rv_seen, 0);
        expect_at("R9", 8'hF5, 'h0C);

        tick(1'b0, 1'b0, 1'b0, 16'h0, 1'b0);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule